// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when a system-basis device leaves its two low-power modes, Sleep and Stop, and records what woke it. It watches four wake lines, the SPI chip-select line, a CAN wake flag from the transceiver, and two internal timers. Every asynchronous line passes through a synchronizer. Once a wake event is found, the block latches the source into a status word that the host clears by reading it. A CAN wake is latched in a separate bit.

The wake lines can be judged in two ways, and the choice applies to all four lines. In direct mode a qualifying edge counts as soon as it is seen. In cyclic mode a timer pulses a bias switch, and each line is sampled a few cycles into every on-window. The result is compared with the sample from the previous window. A separate timed wake can end the low-power mode after a fixed stay. It cannot be enabled together with cyclic sensing.

The exit path depends on the mode. A wake from Sleep turns the core supply back on, runs a reset phase of fixed length, and then gives a one-cycle request to enter Normal Request. A wake from Stop raises an interrupt instead. The configuration word can only be written while the device is in Normal or Standby mode.

Top module: `lpwake_ctrl`

## Requirements
- R1: Mode encoding: 0 Normal, 1 Standby, 2 Sleep, 3 Stop. A configuration write is accepted only in Normal or Standby, and `cfg_o` shows the accepted word. The word layout is: [7:6] sensitivity of lines 2 and 3; [5:4] sensitivity of lines 0 and 1; [3] bias-link bit; [2] bias-auto bit; [1] timed-wake enable; [0] CAN-wake enable.
- R2: A write that sets the timed-wake enable together with both bias bits is rejected, and `cfg_o` keeps its old value.
- R3: Sensitivity codes are: 0 ignore, 1 rising, 2 falling, 3 either edge. In direct mode (bias bits not both 1), in Sleep or Stop, a line edge that matches its pair's code sets that line's bit in `wake_stat_o[3:0]`. An edge that does not match has no effect.
- R4: Cyclic mode applies when both bias bits are 1. In Sleep or Stop, `hs_on_o` is high for CYC_ON cycles of every CYC_PERIOD cycles. A line is judged only by the sample taken CYC_SETTLE cycles into each window, compared with the previous window's sample. A pulse that begins and ends between windows causes no wake.
- R5: With timed wake enabled, a stay of FWU_CYCLES cycles in Sleep or Stop causes a wake that sets `wake_stat_o[5]`.
- R6: In Sleep or Stop, a low-to-high transition of chip-select sets `wake_stat_o[4]`. A high-to-low transition does not cause a wake.
- R7: With CAN wake enabled, a CAN wake flag in Sleep or Stop sets `can_stat_o` and leaves `wake_stat_o` clear. With CAN wake disabled, the flag has no effect.
- R8: In Sleep, `vdd_en_o` is low until a wake. A wake from Sleep raises `vdd_en_o`, holds `sys_rst_o` for RST_LEN cycles, and then pulses `nreq_o` for exactly one cycle.
- R9: A wake from Stop raises `irq_o`, with no reset phase.
- R10: `stat_rd_i` clears `wake_stat_o`, `can_stat_o` and `irq_o`. After reset these outputs are 0, `vdd_en_o` is 1, and `hs_on_o` is 0.
- R11: Outside Sleep and Stop, no source causes a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Current power mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration word to write |
| cfg_o | output | 8 | Accepted configuration |
| wake_in_i | input | 4 | Raw wake lines |
| spi_cs_i | input | 1 | Raw SPI chip-select |
| can_wake_i | input | 1 | CAN wake flag |
| stat_rd_i | input | 1 | Status read, clears latched bits |
| wake_stat_o | output | 6 | Lines [3:0], chip-select [4], timer [5] |
| can_stat_o | output | 1 | CAN wake latched |
| hs_on_o | output | 1 | Bias switch enable |
| vdd_en_o | output | 1 | Core supply enable |
| sys_rst_o | output | 1 | Reset phase after a Sleep wake |
| nreq_o | output | 1 | One-cycle request for Normal Request |
| irq_o | output | 1 | Interrupt after a Stop wake |

## Verification
The hardest case to reach is a line pulse in cyclic mode that falls wholly between two sample windows. The bench waits on `hs_on_o` to find the phase of the timer. It then toggles the line right after a window closes and restores it well before the next window opens. After that it checks that two further windows pass with no wake. Next it holds a change across a window and expects a wake. The direct mode is swept over every line, every sensitivity code and both edge directions.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;

    localparam int WU_LINES = 4;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_SLEEP   = 2'd2,
        MODE_STOP    = 2'd3
    } pm_mode_e;

    typedef enum logic [1:0] {
        SENS_OFF  = 2'd0,
        SENS_RISE = 2'd1,
        SENS_FALL = 2'd2,
        SENS_ANY  = 2'd3
    } sens_e;

    typedef struct packed {
        logic [1:0] sens_hi;
        logic [1:0] sens_lo;
        logic       hs_link;
        logic       hs_auto;
        logic       fwu_en;
        logic       can_en;
    } wu_cfg_t;

    typedef struct packed {
        logic                tmr;
        logic                cs;
        logic [WU_LINES-1:0] lines;
    } wu_stat_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RST  = 2'd1,
        SEQ_NREQ = 2'd2
    } seq_e;

    function automatic logic sens_hit(logic [1:0] s, logic old_v, logic new_v);
        case (sens_e'(s))
            SENS_RISE: return !old_v && new_v;
            SENS_FALL: return old_v && !new_v;
            SENS_ANY:  return old_v != new_v;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic is_cyclic(wu_cfg_t c);
        return c.hs_link && c.hs_auto;
    endfunction

endpackage

// File: rtl/lpwake_sync.sv
module lpwake_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) stg[0] <= '0;
        else       stg[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) stg[s] <= '0;
            else       stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lpwake_timer.sv
module lpwake_timer #(
    parameter int CYC_PERIOD = 16,
    parameter int CYC_ON     = 4,
    parameter int CYC_SETTLE = 2,
    parameter int FWU_CYCLES = 40
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cyc_run_i,
    input  logic fwu_run_i,
    output logic hs_on_o,
    output logic smp_stb_o,
    output logic fwu_done_o
);
    localparam int CW = $clog2(CYC_PERIOD);
    localparam int FW = $clog2(FWU_CYCLES);
    localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PERIOD - 1);
    localparam logic [FW-1:0] FWU_LAST = FW'(FWU_CYCLES - 1);

    logic [CW-1:0] cyc_cnt;
    logic [FW-1:0] fwu_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || !cyc_run_i)     cyc_cnt <= '0;
        else if (cyc_cnt == CYC_LAST) cyc_cnt <= '0;
        else                          cyc_cnt <= cyc_cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !fwu_run_i)     fwu_cnt <= '0;
        else if (fwu_cnt != FWU_LAST) fwu_cnt <= fwu_cnt + 1'b1;
    end

    assign hs_on_o    = cyc_run_i && (cyc_cnt < CW'(CYC_ON));
    assign smp_stb_o  = cyc_run_i && (cyc_cnt == CW'(CYC_SETTLE));
    assign fwu_done_o = fwu_run_i && (fwu_cnt == FWU_LAST);
endmodule

// File: rtl/lpwake_seq.sv
module lpwake_seq import lpwake_pkg::*; #(
    parameter int RST_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic sys_rst_o,
    output logic nreq_o
);
    localparam int RW = $clog2(RST_LEN + 1);

    seq_e          st;
    logic [RW-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SEQ_IDLE: if (start_i) begin
                    st  <= SEQ_RST;
                    cnt <= RW'(RST_LEN - 1);
                end
                SEQ_RST: begin
                    if (cnt == '0) st <= SEQ_NREQ;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assign sys_rst_o = (st == SEQ_RST);
    assign nreq_o    = (st == SEQ_NREQ);
endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl import lpwake_pkg::*; #(
    parameter int SYNC_STAGES = 2,
    parameter int CYC_PERIOD  = 16,
    parameter int CYC_ON      = 4,
    parameter int CYC_SETTLE  = 2,
    parameter int FWU_CYCLES  = 40,
    parameter int RST_LEN     = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [1:0]            mode_i,
    input  logic                  cfg_we_i,
    input  logic [7:0]            cfg_wdata_i,
    output logic [7:0]            cfg_o,
    input  logic [WU_LINES-1:0]   wake_in_i,
    input  logic                  spi_cs_i,
    input  logic                  can_wake_i,
    input  logic                  stat_rd_i,
    output logic [WU_LINES+1:0]   wake_stat_o,
    output logic                  can_stat_o,
    output logic                  hs_on_o,
    output logic                  vdd_en_o,
    output logic                  sys_rst_o,
    output logic                  nreq_o,
    output logic                  irq_o
);
    localparam int SW = WU_LINES + 1;

    pm_mode_e md;
    wu_cfg_t  cfg_q, cfg_in;
    wu_stat_t stat_q, stat_hit;
    logic     can_q, irq_q, woken;
    logic     lp, cyc, armed;

    assign md     = pm_mode_e'(mode_i);
    assign cfg_in = wu_cfg_t'(cfg_wdata_i);
    assign lp     = (md == MODE_SLEEP) || (md == MODE_STOP);
    assign cyc    = is_cyclic(cfg_q);
    assign armed  = lp && !woken;

    // configuration: writable only outside low power, timed wake and cyclic exclusive
    always_ff @(posedge clk_i) begin
        if (rst_i) cfg_q <= '0;
        else if (cfg_we_i && !lp && !(cfg_in.fwu_en && is_cyclic(cfg_in)))
            cfg_q <= cfg_in;
    end

    // synchronizers
    logic [SW-1:0] raw_s, syn_s;
    logic [WU_LINES-1:0] syn_in, prev_in, samp_q, line_hit;
    logic syn_cs, prev_cs, samp_ok;

    assign raw_s = {spi_cs_i, wake_in_i};

    lpwake_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_s),
        .q_o   (syn_s)
    );

    assign syn_in = syn_s[WU_LINES-1:0];
    assign syn_cs = syn_s[WU_LINES];

    // timers
    logic smp_stb, fwu_done;

    lpwake_timer #(
        .CYC_PERIOD (CYC_PERIOD),
        .CYC_ON     (CYC_ON),
        .CYC_SETTLE (CYC_SETTLE),
        .FWU_CYCLES (FWU_CYCLES)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cyc_run_i  (armed && cyc),
        .fwu_run_i  (armed && cfg_q.fwu_en),
        .hs_on_o    (hs_on_o),
        .smp_stb_o  (smp_stb),
        .fwu_done_o (fwu_done)
    );

    // edge history and cyclic samples
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_in <= '0;
            prev_cs <= 1'b0;
            samp_q  <= '0;
            samp_ok <= 1'b0;
        end else begin
            prev_in <= syn_in;
            prev_cs <= syn_cs;
            if (!(armed && cyc)) samp_ok <= 1'b0;
            else if (smp_stb) begin
                samp_q  <= syn_in;
                samp_ok <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < WU_LINES; i++) begin : g_line
        logic [1:0] sens;
        assign sens = (i < WU_LINES/2) ? cfg_q.sens_lo : cfg_q.sens_hi;
        assign line_hit[i] = armed && (cyc
            ? (smp_stb && samp_ok && sens_hit(sens, samp_q[i], syn_in[i]))
            : sens_hit(sens, prev_in[i], syn_in[i]));
    end

    logic can_hit, any_hit;

    always_comb begin
        stat_hit.lines = line_hit;
        stat_hit.cs    = armed && !prev_cs && syn_cs;
        stat_hit.tmr   = fwu_done;
        can_hit        = armed && cfg_q.can_en && can_wake_i;
        any_hit        = (|stat_hit) || can_hit;
    end

    // latched status, clear on read with set priority
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
            can_q  <= 1'b0;
            irq_q  <= 1'b0;
            woken  <= 1'b0;
        end else begin
            stat_q <= (stat_rd_i ? '0 : stat_q) | stat_hit;
            can_q  <= (!stat_rd_i && can_q) || can_hit;
            irq_q  <= (!stat_rd_i && irq_q) || (any_hit && md == MODE_STOP);
            woken  <= lp && (woken || any_hit);
        end
    end

    lpwake_seq #(.RST_LEN(RST_LEN)) u_seq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .start_i   (any_hit && md == MODE_SLEEP),
        .sys_rst_o (sys_rst_o),
        .nreq_o    (nreq_o)
    );

    assign cfg_o       = cfg_q;
    assign wake_stat_o = stat_q;
    assign can_stat_o  = can_q;
    assign irq_o       = irq_q;
    assign vdd_en_o    = !((md == MODE_SLEEP) && !woken);
endmodule

// File: rtl/lpwake_chk.sv
module lpwake_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] mode_i,
    input logic [7:0] cfg_o,
    input logic       hs_on_o,
    input logic       vdd_en_o,
    input logic       sys_rst_o,
    input logic       nreq_o,
    input logic       irq_o
);
    AST_CFG_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(cfg_o[1] && cfg_o[3] && cfg_o[2]));                                  // R2
    AST_BIAS_ONLY_CYCLIC: assert property (@(posedge clk_i) disable iff (rst_i)
        hs_on_o |-> (mode_i[1] && cfg_o[3] && cfg_o[2]));                      // R4
    AST_RST_WITH_SUPPLY: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sys_rst_o) |-> vdd_en_o);                                        // R8
    AST_NREQ_AFTER_RST: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sys_rst_o) |-> nreq_o);                                          // R8
    AST_NREQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        nreq_o |=> !nreq_o);                                                   // R8
    AST_IRQ_FROM_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> $past(mode_i) == 2'd3);                               // R9
endmodule

bind lpwake_ctrl lpwake_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .mode_i    (mode_i),
    .cfg_o     (cfg_o),
    .hs_on_o   (hs_on_o),
    .vdd_en_o  (vdd_en_o),
    .sys_rst_o (sys_rst_o),
    .nreq_o    (nreq_o),
    .irq_o     (irq_o)
);

// File: tb/lpwake_ctrl_tb_top.sv
module lpwake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD = 16, ON = 4, FWU = 40, RLEN = 4;

    logic       clk = 0, rst = 1;
    logic [1:0] mode = 0;
    logic       cfg_we = 0;
    logic [7:0] cfg_wdata = 0, cfg_o;
    logic [3:0] wake_in = 0;
    logic       cs = 1, can_wake = 0, stat_rd = 0;
    logic [5:0] wake_stat;
    logic       can_stat, hs_on, vdd_en, sys_rst, nreq, irq;

    int n_tests = 0, n_fail = 0;
    int rst_cyc = 0, nreq_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpwake_ctrl #(.CYC_PERIOD(PERIOD), .CYC_ON(ON), .CYC_SETTLE(2),
                  .FWU_CYCLES(FWU), .RST_LEN(RLEN)) dut_i (
        .clk_i(clk), .rst_i(rst), .mode_i(mode), .cfg_we_i(cfg_we),
        .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_o), .wake_in_i(wake_in),
        .spi_cs_i(cs), .can_wake_i(can_wake), .stat_rd_i(stat_rd),
        .wake_stat_o(wake_stat), .can_stat_o(can_stat), .hs_on_o(hs_on),
        .vdd_en_o(vdd_en), .sys_rst_o(sys_rst), .nreq_o(nreq), .irq_o(irq));

    always @(negedge clk) begin
        if (sys_rst) rst_cyc++;
        if (nreq)    nreq_cyc++;
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic clr_stat;
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic wait_hs_fall;
        while (!hs_on) @(negedge clk);
        while (hs_on)  @(negedge clk);
    endtask

    initial begin
        cyc(3); rst = 0; cyc(1);
        // R10 reset state
        chk("R10 stat", wake_stat, 0);
        chk("R10 irq", irq, 0);
        chk("R10 vdd", vdd_en, 1);
        chk("R10 hs", hs_on, 0);

        // R3 direct sweep: every line, code and direction in Stop
        for (int code = 0; code < 4; code++) begin
            for (int ln = 0; ln < 4; ln++) begin
                for (int rise = 0; rise < 2; rise++) begin
                    automatic int hit = (code == 3) || (code == 1 && rise == 1) || (code == 2 && rise == 0);
                    mode = 0;
                    wr_cfg({code[1:0], code[1:0], 4'b0000});
                    wake_in = rise ? 4'b0000 : 4'b1111;
                    cyc(5); clr_stat;
                    mode = 3; cyc(2);
                    wake_in[ln] = rise[0];
                    cyc(6);
                    chk("R3 line bits", wake_stat[3:0], hit ? (1 << ln) : 0);
                    chk("R9 stop irq", irq, hit);
                    chk("R9 no reset phase", rst_cyc, 0);
                    mode = 0; cyc(2); clr_stat;
                end
            end
        end

        // R11 edges outside low power are not wakes
        wr_cfg(8'hF0); wake_in = 0; cyc(5); clr_stat;
        wake_in = 4'hF; cyc(6);
        chk("R11 no wake in normal", wake_stat, 0);

        // R1 writes ignored in Sleep
        wr_cfg(8'h51); chk("R1 accepted", cfg_o, 8'h51);
        mode = 2; cyc(2);
        wr_cfg(8'h02); chk("R1 ignored in sleep", cfg_o, 8'h51);
        mode = 1; cyc(2);
        wr_cfg(8'h02); chk("R1 accepted in standby", cfg_o, 8'h02);
        // R2 exclusive write rejected
        wr_cfg(8'h0E); chk("R2 rejected", cfg_o, 8'h02);
        mode = 0; wr_cfg(8'h00); cyc(2); clr_stat;

        // R6/R8 chip-select wake from Sleep
        cs = 1; cyc(4); rst_cyc = 0; nreq_cyc = 0;
        mode = 2; cyc(2);
        chk("R8 supply off in sleep", vdd_en, 0);
        cs = 0; cyc(6);
        chk("R6 falling ignored", wake_stat, 0);
        chk("R8 supply still off", vdd_en, 0);
        cs = 1; cyc(5);
        chk("R6 cs bit", wake_stat, 6'b010000);
        chk("R8 supply on", vdd_en, 1);
        chk("R8 no irq from sleep", irq, 0);
        cyc(RLEN + 4);
        chk("R8 reset length", rst_cyc, RLEN);
        chk("R8 single nreq", nreq_cyc, 1);
        mode = 0; cyc(2); clr_stat;
        chk("R10 cleared", wake_stat, 0);

        // R5 timed wake
        wr_cfg(8'h02); mode = 3;
        cyc(FWU - 2);
        chk("R5 not yet", irq, 0);
        cyc(4);
        chk("R5 timer bit", wake_stat, 6'b100000);
        chk("R5 irq", irq, 1);
        mode = 0; cyc(2); clr_stat;
        chk("R10 irq cleared", irq, 0);

        // R7 CAN wake
        wr_cfg(8'h00); mode = 3; cyc(2); can_wake = 1; cyc(3);
        chk("R7 disabled", can_stat + irq, 0);
        can_wake = 0; mode = 0; cyc(2);
        wr_cfg(8'h01); mode = 3; cyc(2); can_wake = 1; cyc(3);
        chk("R7 can bit", can_stat, 1);
        chk("R7 status clear", wake_stat, 0);
        can_wake = 0; mode = 0; cyc(2); clr_stat;
        chk("R10 can cleared", can_stat, 0);

        // R4 cyclic sensing
        wake_in = 0; wr_cfg(8'hFC); cyc(4); clr_stat;
        mode = 3;
        wait_hs_fall;
        begin
            automatic int on_cnt = 0;
            while (!hs_on) @(negedge clk);
            while (hs_on) begin on_cnt++; @(negedge clk); end
            chk("R4 window length", on_cnt, ON);
        end
        wake_in[0] = 1; cyc(3); wake_in[0] = 0;
        wait_hs_fall; wait_hs_fall;
        chk("R4 pulse between windows", wake_stat, 0);
        wake_in[2] = 1;
        wait_hs_fall; cyc(2);
        chk("R4 held change", wake_stat, 6'b000100);
        chk("R4 irq", irq, 1);
        cyc(PERIOD);
        chk("R4 bias off after wake", hs_on, 0);
        mode = 0; cyc(2); clr_stat;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule